// File: doc/BRIEF.md
# Two-wire potentiometer command slave

This block is the serial front end of a four-channel digital potentiometer controller. It watches a two-wire bus (clock and data lines) with the system clock, finds start and stop conditions, checks the slave address, takes in an instruction byte and, when the opcode calls for it, a data byte. It answers with acknowledge bits and read data through an output enable: the enable pulls the shared data line low and an external pull-up supplies the high level.

Each accepted command becomes a one-cycle request to a register bank that sits outside this block. The bank holds the wiper positions and the stored data registers. Reads take their data from the bank's response bus in the cycle the request is shown. One opcode opens an increment/decrement phase that runs until stop, where every bus clock pulse moves the chosen wiper by one step. Commands that write nonvolatile storage are held back until the stop condition. While the bank reports a store in progress, the slave does not acknowledge its own address, which lets the master poll for completion.

Top module: `pot_cmd_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Out of reset the block is idle, `sda_oe` is 0 and `req_valid` is 0.
- R2: The first byte after a start is taken MSB first on clock rising edges. The slave acknowledges it only when bits 7:4 equal 0101 and bits 3:0 equal `dev_addr`. Any other value gets no acknowledge, and the rest of the transaction up to the next start is ignored.
- R3: The slave acknowledges by holding `sda_oe` high for the ninth clock. It does this after a matching address, after a defined instruction byte, and after the data byte of a write command.
- R4: Instruction byte layout: bits 7:4 opcode, bits 3:2 register select, bits 1:0 pot select. Opcodes map to `req_kind` codes as follows: 1001→1 read wiper, 1010→2 write wiper, 1011→3 read data register, 1100→4 write data register, 1101→5 data register to wiper, 1110→6 wiper to data register, 0001→7 global data register to wiper, 1000→8 global wiper to data register. Step up is 9 and step down is 10. Every request is a single-cycle `req_valid` pulse. It carries the received pot and register fields, and `req_wdata` is zero unless the kind is 2 or 4.
- R5: For kinds 1 and 3, the request is issued at the clock falling edge that ends the instruction acknowledge. `rsp_rdata` is captured in the cycle the request is shown and shifted out MSB first, one bit per clock low phase. The master's acknowledge bit after the byte is ignored.
- R6: Kinds 2, 5 and 7 are issued at the clock falling edge that ends the last acknowledge of the command, before any stop.
- R7: Kinds 4, 6 and 8 are issued only in the cycle after the stop condition is detected.
- R8: A start that arrives while a kind 4, 6 or 8 command waits for its stop cancels that command with no request, and the new start opens a new transaction.
- R9: After opcode 0010 is acknowledged, each later clock pulse that ends with a falling edge before a stop produces one request. The data line level at the rising edge selects 9 (high) or 10 (low). A pulse cut short by a stop produces nothing.
- R10: While `nv_busy` is high a matching address gets no acknowledge. The same address sequence is acknowledged once `nv_busy` is low.
- R11: Opcodes not listed in R4 or R9 get no acknowledge, issue no request, and leave the slave idle until the next start.
- R12: `sda_oe` rises only within two cycles after a detected clock falling edge, and changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 4 | Pin-strapped low address bits |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low |
| nv_busy | input | 1 | Bank is running a nonvolatile store |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 4 | Request code per R4 |
| req_pot | output | 2 | Pot select from the instruction byte |
| req_reg | output | 2 | Register select from the instruction byte |
| req_wdata | output | 8 | Write data for kinds 2 and 4, else zero |
| rsp_rdata | input | 8 | Read data from the bank, valid while a read request is shown |

## Verification
The address byte is tried with a match, a wrong low nibble and a wrong device-type nibble, which separates the two halves of the compare. Every opcode class is sent: reads with data patterns that have both MSB states, volatile writes that must show up before the stop, and stores that must show up only after it. A store cut off by a repeated start tells cancellation apart from late issue. A mixed up/down step sequence ended by a stop shows whether direction is sampled per pulse and whether the stop pulse is counted. Polling with the busy flag set and then cleared, together with undefined opcodes, checks that acknowledges are refused only when they should be.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int POT_W  = 2;
  localparam int REG_W  = 2;
  localparam int ADDR_W = 4;
  localparam int KIND_W = 4;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [KIND_W-1:0] {
    REQ_NONE      = 4'd0,
    REQ_RD_WIPER  = 4'd1,
    REQ_WR_WIPER  = 4'd2,
    REQ_RD_DREG   = 4'd3,
    REQ_WR_DREG   = 4'd4,
    REQ_LD_WIPER  = 4'd5,
    REQ_ST_WIPER  = 4'd6,
    REQ_GLD_WIPER = 4'd7,
    REQ_GST_WIPER = 4'd8,
    REQ_STEP_UP   = 4'd9,
    REQ_STEP_DN   = 4'd10
  } req_kind_e;

  typedef struct packed {
    logic      valid;
    req_kind_e kind;
    logic      has_data;
    logic      is_read;
    logic      is_nv;
    logic      is_step;
  } insn_info_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [OP_W-1:0]   dev_type,
                                    input logic [ADDR_W-1:0] pins);
    return (b[BYTE_W-1 -: OP_W] == dev_type) && (b[ADDR_W-1:0] == pins);
  endfunction

  function automatic logic [POT_W-1:0] pot_field(input logic [BYTE_W-1:0] b);
    return b[POT_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] reg_field(input logic [BYTE_W-1:0] b);
    return b[POT_W +: REG_W];
  endfunction

  function automatic logic kind_is_nv(input req_kind_e k);
    return (k == REQ_WR_DREG) || (k == REQ_ST_WIPER) || (k == REQ_GST_WIPER);
  endfunction

  function automatic logic kind_is_step(input req_kind_e k);
    return (k == REQ_STEP_UP) || (k == REQ_STEP_DN);
  endfunction
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

  // R1: a bus condition needs a steady high clock, so it never meets a clock edge
  a_r1_cond_not_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> !(scl_rise || scl_fall));
endmodule

// File: rtl/pot_insn_decode.sv
module pot_insn_decode import potcmd_pkg::*; (
  input  logic [BYTE_W-1:0] insn_byte,
  output insn_info_t        info
);
  logic [OP_W-1:0] opcode;
  assign opcode = insn_byte[BYTE_W-1 -: OP_W];

  always_comb begin
    info = '{valid: 1'b1, kind: REQ_NONE, has_data: 1'b0,
             is_read: 1'b0, is_nv: 1'b0, is_step: 1'b0};
    unique case (opcode)
      4'b1001: begin info.kind = REQ_RD_WIPER;  info.is_read  = 1'b1; end
      4'b1010: begin info.kind = REQ_WR_WIPER;  info.has_data = 1'b1; end
      4'b1011: begin info.kind = REQ_RD_DREG;   info.is_read  = 1'b1; end
      4'b1100: begin info.kind = REQ_WR_DREG;   info.has_data = 1'b1; info.is_nv = 1'b1; end
      4'b1101: info.kind = REQ_LD_WIPER;
      4'b1110: begin info.kind = REQ_ST_WIPER;  info.is_nv = 1'b1; end
      4'b0001: info.kind = REQ_GLD_WIPER;
      4'b1000: begin info.kind = REQ_GST_WIPER; info.is_nv = 1'b1; end
      4'b0010: begin info.kind = REQ_STEP_UP;   info.is_step = 1'b1; end
      default: info.valid = 1'b0;
    endcase
  end

  // R11: an undefined opcode never carries a request kind
  always_comb begin
    a_r11_undef_no_kind: assert (info.valid || info.kind == REQ_NONE);
  end
endmodule

// File: rtl/pot_cmd_fsm.sv
module pot_cmd_fsm import potcmd_pkg::*; #(
  parameter logic [OP_W-1:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              nv_busy,
  input  insn_info_t        info,
  output logic [BYTE_W-1:0] insn_byte,
  output logic              sda_oe,
  output logic              req_valid,
  output req_kind_e         req_kind,
  output logic [POT_W-1:0]  req_pot,
  output logic [REG_W-1:0]  req_reg,
  output logic [BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0] rsp_rdata
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSN, ST_INSN_ACK, ST_DATA,
    ST_DATA_ACK, ST_RD_LOAD, ST_RD_BIT, ST_RD_MACK, ST_STEP, ST_HOLD
  } state_e;

  state_e            state_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              byte_full;
  insn_info_t        info_q;
  logic [POT_W-1:0]  pot_q;
  logic [REG_W-1:0]  reg_q;
  logic [BYTE_W-1:0] data_q;
  logic              nv_pend;
  logic              step_dir, step_armed;
  logic              rx_state, byte_end;

  assign insn_byte = shreg;
  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_INSN) || (state_q == ST_DATA);
  assign byte_end  = rx_state && scl_fall && byte_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_full  <= 1'b0;
      info_q     <= '0;
      pot_q      <= '0;
      reg_q      <= '0;
      data_q     <= '0;
      nv_pend    <= 1'b0;
      step_dir   <= 1'b0;
      step_armed <= 1'b0;
      sda_oe     <= 1'b0;
      req_valid  <= 1'b0;
      req_kind   <= REQ_NONE;
      req_pot    <= '0;
      req_reg    <= '0;
      req_wdata  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        bit_cnt    <= '0;
        byte_full  <= 1'b0;
        nv_pend    <= 1'b0;
        step_armed <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        sda_oe     <= 1'b0;
        step_armed <= 1'b0;
        nv_pend    <= 1'b0;
        if (nv_pend) begin
          req_valid <= 1'b1;
          req_kind  <= info_q.kind;
          req_pot   <= pot_q;
          req_reg   <= reg_q;
          req_wdata <= info_q.has_data ? data_q : '0;
        end
      end else begin
        if (rx_state && scl_rise) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W-1)) byte_full <= 1'b1;
        end
        if (byte_end) byte_full <= 1'b0;
        unique case (state_q)
          ST_ADDR: if (byte_end) begin
            if (addr_hit(shreg, DEV_TYPE, dev_addr) && !nv_busy) begin
              sda_oe  <= 1'b1;
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state_q <= ST_INSN;
          end
          ST_INSN: if (byte_end) begin
            if (info.valid) begin
              info_q  <= info;
              pot_q   <= pot_field(shreg);
              reg_q   <= reg_field(shreg);
              sda_oe  <= 1'b1;
              state_q <= ST_INSN_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_INSN_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            if (info_q.has_data) begin
              state_q <= ST_DATA;
            end else if (info_q.is_step) begin
              state_q <= ST_STEP;
            end else if (info_q.is_nv) begin
              nv_pend <= 1'b1;
              state_q <= ST_HOLD;
            end else begin
              req_valid <= 1'b1;
              req_kind  <= info_q.kind;
              req_pot   <= pot_q;
              req_reg   <= reg_q;
              req_wdata <= '0;
              state_q   <= info_q.is_read ? ST_RD_LOAD : ST_HOLD;
            end
          end
          ST_DATA: if (byte_end) begin
            data_q  <= shreg;
            sda_oe  <= 1'b1;
            state_q <= ST_DATA_ACK;
          end
          ST_DATA_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            state_q <= ST_HOLD;
            if (info_q.is_nv) begin
              nv_pend <= 1'b1;
            end else begin
              req_valid <= 1'b1;
              req_kind  <= info_q.kind;
              req_pot   <= pot_q;
              req_reg   <= reg_q;
              req_wdata <= data_q;
            end
          end
          ST_RD_LOAD: begin
            shreg   <= rsp_rdata;
            sda_oe  <= ~rsp_rdata[BYTE_W-1];
            bit_cnt <= '0;
            state_q <= ST_RD_BIT;
          end
          ST_RD_BIT: if (scl_fall) begin
            if (bit_cnt == CNT_W'(BYTE_W-1)) begin
              sda_oe  <= 1'b0;
              state_q <= ST_RD_MACK;
            end else begin
              shreg   <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe  <= ~shreg[BYTE_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RD_MACK: if (scl_fall) state_q <= ST_HOLD;
          ST_STEP: begin
            if (scl_rise) begin
              step_dir   <= sda_s;
              step_armed <= 1'b1;
            end else if (scl_fall && step_armed) begin
              step_armed <= 1'b0;
              req_valid  <= 1'b1;
              req_kind   <= step_dir ? REQ_STEP_UP : REQ_STEP_DN;
              req_pot    <= pot_q;
              req_reg    <= reg_q;
              req_wdata  <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: the output enable is raised only in answer to a clock falling edge
  a_r12_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(scl_fall) || $past(scl_fall, 2)));
  // R12: the output enable never moves while the clock line is high
  a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  // R7: stores reach the bank only right after a stop
  a_r7_nv_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind_is_nv(req_kind)) |-> $past(stop_det));
  // R9: a step request follows a clock falling edge
  a_r9_step_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind_is_step(req_kind)) |-> $past(scl_fall));
  // R4: requests are single-cycle pulses
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R10: an address acknowledge is never given while a store is busy
  a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && state_q == ST_ADDR_ACK) |-> !$past(nv_busy));
endmodule

// File: rtl/pot_cmd_slave.sv
module pot_cmd_slave import potcmd_pkg::*; #(
  parameter int              SYNC_STAGES = 2,
  parameter logic [OP_W-1:0] DEV_TYPE    = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              nv_busy,
  output logic              req_valid,
  output logic [KIND_W-1:0] req_kind,
  output logic [POT_W-1:0]  req_pot,
  output logic [REG_W-1:0]  req_reg,
  output logic [BYTE_W-1:0] req_wdata,
  input  logic [BYTE_W-1:0] rsp_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] insn_byte;
  insn_info_t        info;
  req_kind_e         kind_e;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  pot_insn_decode u_dec (.insn_byte(insn_byte), .info(info));

  pot_cmd_fsm #(.DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .dev_addr(dev_addr), .nv_busy(nv_busy), .info(info),
    .insn_byte(insn_byte), .sda_oe(sda_oe),
    .req_valid(req_valid), .req_kind(kind_e), .req_pot(req_pot),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata));

  assign req_kind = kind_e;
endmodule

// File: tb/pot_cmd_slave_tb.sv
module pot_cmd_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 6;
  localparam int WATCHDOG = 150000;
  localparam logic [3:0] MY_ADDR = 4'hA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, nv_busy = 1'b0;
  logic sda_oe, req_valid, sda_bus;
  logic [3:0] req_kind;
  logic [1:0] req_pot, req_reg;
  logic [7:0] req_wdata, rsp_rdata;

  int n_tests = 0, n_fail = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  // bank model: combinational read data per R5
  function automatic logic [7:0] bank_val(input logic [3:0] k, input logic [1:0] p, input logic [1:0] r);
    if (k == 4'd1) return 8'hC3 ^ {6'b0, p};
    return 8'h5A ^ {4'b0, p, r};
  endfunction
  assign rsp_rdata = req_valid ? bank_val(req_kind, req_pot, req_reg) : 8'h00;

  pot_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .dev_addr(MY_ADDR), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .nv_busy(nv_busy), .req_valid(req_valid), .req_kind(req_kind),
    .req_pot(req_pot), .req_reg(req_reg), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference: every clock, each request must equal the next predicted one (R4)
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected request", {req_kind, req_pot, req_reg, req_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({req_kind, req_pot, req_reg, req_wdata} == e, "R4 request fields",
            {req_kind, req_pot, req_reg, req_wdata}, e);
      end
    end
  end

  task automatic expect_req(input int k, input logic [1:0] p, input logic [1:0] r, input logic [7:0] d);
    exp_q.push_back({4'(k), p, r, d});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_cyc(QTR); scl_m = 1'b1; wait_cyc(QTR);
    sda_m = 1'b0; wait_cyc(QTR); scl_m = 1'b0; wait_cyc(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(QTR); scl_m = 1'b1; wait_cyc(QTR);
    sda_m = 1'b1; wait_cyc(2*QTR);
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; wait_cyc(QTR); scl_m = 1'b1; wait_cyc(2*QTR);
    scl_m = 1'b0; wait_cyc(QTR);
  endtask

  task automatic bus_sample(output logic b);
    sda_m = 1'b1; wait_cyc(QTR); scl_m = 1'b1; wait_cyc(QTR);
    b = sda_bus; wait_cyc(QTR); scl_m = 1'b0; wait_cyc(QTR);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_sample(s);
    acked = !s;
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_sample(v[i]);
    bus_bit(1'b1);
  endtask

  task automatic drain(input string req);
    wait_cyc(30);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic open_cmd(input logic [7:0] insn, input bit want, input string req);
    logic a;
    bus_start();
    send_byte({4'b0101, MY_ADDR}, a);
    chk(a == 1'b1, "R3 address acknowledge", a, 1);
    send_byte(insn, a);
    chk(a == want, req, a, want);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rd;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    chk(sda_oe == 1'b0 && req_valid == 1'b0, "R1 reset idle", {sda_oe, req_valid}, 0);

    // R2: wrong pin address and wrong device type
    bus_start(); send_byte({4'b0101, 4'hB}, a);
    chk(a == 1'b0, "R2 wrong address ignored", a, 0);
    send_byte(8'b1010_0000, a);
    chk(a == 1'b0, "R2 rest of transaction ignored", a, 0);
    bus_stop();
    bus_start(); send_byte({4'b0111, MY_ADDR}, a);
    chk(a == 1'b0, "R2 wrong device type", a, 0);
    bus_stop(); drain("R2 no request");

    // R6: volatile wiper write issued before stop
    expect_req(2, 2'd2, 2'd0, 8'h3C);
    open_cmd(8'b1010_00_10, 1'b1, "R3 instruction acknowledge");
    send_byte(8'h3C, a);
    chk(a == 1'b1, "R3 data acknowledge", a, 1);
    wait_cyc(4);
    chk(exp_q.size() == 0, "R6 write wiper before stop", exp_q.size(), 0);
    bus_stop(); drain("R6 write wiper");

    // R5: reads
    expect_req(1, 2'd1, 2'd0, 8'h00);
    open_cmd(8'b1001_00_01, 1'b1, "R3 read wiper ack");
    read_byte(rd);
    chk(rd == 8'hC2, "R5 read wiper data", rd, 8'hC2);
    bus_stop(); drain("R5 read wiper");
    expect_req(3, 2'd3, 2'd2, 8'h00);
    open_cmd(8'b1011_10_11, 1'b1, "R3 read dreg ack");
    read_byte(rd);
    chk(rd == 8'h54, "R5 read data register", rd, 8'h54);
    bus_stop(); drain("R5 read dreg");

    // R7: data register write only on stop
    open_cmd(8'b1100_11_00, 1'b1, "R3 write dreg ack");
    send_byte(8'h81, a);
    chk(a == 1'b1, "R3 write dreg data ack", a, 1);
    wait_cyc(20);
    expect_req(4, 2'd0, 2'd3, 8'h81);
    bus_stop(); drain("R7 write dreg on stop");

    // R8: store cancelled by a repeated start, new command still served
    open_cmd(8'b1100_01_01, 1'b1, "R3 aborted store ack");
    send_byte(8'h77, a);
    wait_cyc(20);
    expect_req(5, 2'd2, 2'd1, 8'h00);
    open_cmd(8'b1101_01_10, 1'b1, "R8 command after repeated start");
    bus_stop(); drain("R8 abort leaves only transfer");

    // R7: wiper-to-register and global transfers
    open_cmd(8'b1110_10_01, 1'b1, "R3 store wiper ack");
    wait_cyc(20);
    expect_req(6, 2'd1, 2'd2, 8'h00);
    bus_stop(); drain("R7 store wiper");
    expect_req(7, 2'd0, 2'd3, 8'h00);
    open_cmd(8'b0001_11_00, 1'b1, "R6 global load ack");
    bus_stop(); drain("R6 global load");
    open_cmd(8'b1000_01_00, 1'b1, "R3 global store ack");
    wait_cyc(20);
    expect_req(8, 2'd0, 2'd1, 8'h00);
    bus_stop(); drain("R7 global store");

    // R9: step sequence, stop pulse adds nothing
    expect_req(9, 2'd3, 2'd0, 8'h00);
    expect_req(9, 2'd3, 2'd0, 8'h00);
    expect_req(10, 2'd3, 2'd0, 8'h00);
    expect_req(9, 2'd3, 2'd0, 8'h00);
    expect_req(10, 2'd3, 2'd0, 8'h00);
    open_cmd(8'b0010_00_11, 1'b1, "R9 step ack");
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b0);
    bus_stop(); drain("R9 step requests");

    // R11: undefined opcodes
    open_cmd(8'b0000_00_00, 1'b0, "R11 opcode 0000 refused");
    bus_stop();
    open_cmd(8'b1111_01_01, 1'b0, "R11 opcode 1111 refused");
    send_byte(8'hFF, a);
    chk(a == 1'b0, "R11 idle after undefined opcode", a, 0);
    bus_stop(); drain("R11 no request");

    // R10: acknowledge polling
    nv_busy = 1'b1;
    bus_start(); send_byte({4'b0101, MY_ADDR}, a);
    chk(a == 1'b0, "R10 busy refuses address", a, 0);
    bus_stop();
    nv_busy = 1'b0;
    bus_start(); send_byte({4'b0101, MY_ADDR}, a);
    chk(a == 1'b1, "R10 acknowledged when free", a, 1);
    bus_stop();
    chk(sda_oe == 1'b0, "R12 released after stop", sda_oe, 0);
    drain("R10 no request");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule